// File: doc/BRIEF.md
# Masked Register Save/Restore Sequencer

This block moves a selected set of registers between a 64-entry register file and memory, one register per cycle. The registers are chosen at run time. The block takes the caller's live preservation mask and a per-function constant that lists the registers the function touches, and ANDs the two. It copies only the registers that are set in both. A store direction saves registers to the stack, and a load direction restores them using the same word order, so a restore exactly reverses a save.

An optional chunk mode limits the operation to one group of 16 registers. A group with no selected bits finishes at once with no memory traffic. Before any transfer, the block holds for a short pre-check window in which an address-translation fault may arrive. A fault in that window aborts the whole operation before any state changes. The block reports how many registers it moved and the matching byte offset, so the stack pointer can be adjusted.

Top module: `regmask_xfer`

## Requirements
- R1: The transfer set is `live_mask & used_mask`. Bit i selects register i, and only selected registers are read from or written to.
- R2: In store direction (`dir_load`=0), the k-th selected register in ascending index order is written to address `base_addr + 8*k`. Each transfer asserts `mem_req` with `mem_we`=1, and the addresses rise by 8 from one transfer to the next.
- R3: In load direction (`dir_load`=1), the k-th selected register in ascending order receives the word at `base_addr + 8*k`. Unselected registers are left unchanged, and `mem_we` is 0.
- R4: With `chunk_en`=1, only mask bits 16n to 16n+15 take part, where n = `chunk_sel` (0 to 3).
- R5: When the transfer set (after chunk limiting) is empty, `done` rises in the cycle after `start` is sampled, `xfer_count` is 0, and there is no memory or register-file traffic.
- R6: `xfer_count` equals the number of selected registers, and `sp_adjust` equals `xfer_count*8`. Both are valid from `done` until the next start.
- R7: A non-empty operation spends PRECHK cycles with `busy`=1 and no traffic, then makes one transfer per cycle.
- R8: If `xlat_fault` is high during the pre-check, the operation aborts with no memory or register writes. `fault_exc` rises together with `done` and stays high until the next start.
- R9: `done` is a one-cycle pulse in the cycle after the last transfer. A non-empty operation therefore takes PRECHK + count + 1 cycles from the start edge to `done`.
- R10: After reset, `busy`, `done`, `fault_exc`, `mem_req` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| dir_load | input | 1 | 1 = restore from memory, 0 = save to memory |
| chunk_en | input | 1 | Limit the operation to one 16-register group |
| chunk_sel | input | 2 | Group index when chunk mode is on |
| live_mask | input | 64 | Live preservation mask |
| used_mask | input | 64 | Per-function used-register constant |
| base_addr | input | 32 | Stack address of the first word |
| xlat_fault | input | 1 | Translation fault during the pre-check |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_exc | output | 1 | Operation aborted by a fault |
| xfer_count | output | 7 | Number of registers moved |
| sp_adjust | output | 32 | Byte offset for the stack pointer |
| rf_raddr | output | 6 | Register-file read index |
| rf_rdata | input | 64 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 6 | Register-file write index |
| rf_wdata | output | 64 | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, same cycle as the request |

## Verification
The bench builds the block with its default parameters: 64 registers, 16-register chunks and a 3-cycle pre-check. This makes the extreme registers 0 and 63 reachable, along with every one of the four groups. It also keeps each operation short enough that save, restore, empty-group and abort cases can all be checked with exact cycle counts. The bench compares whole memory and register-file images against values it computes from the mask, so it detects any transfer that lands in the wrong order or slot, or at a stray address.

// File: rtl/regmask_xfer.sv
module regmask_xfer #(
  parameter int NREG   = 64,
  parameter int DW     = 64,
  parameter int AW     = 32,
  parameter int CHUNK  = 16,
  parameter int PRECHK = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          dir_load,
  input  logic                          chunk_en,
  input  logic [$clog2(NREG/CHUNK)-1:0] chunk_sel,
  input  logic [NREG-1:0]               live_mask,
  input  logic [NREG-1:0]               used_mask,
  input  logic [AW-1:0]                 base_addr,
  input  logic                          xlat_fault,
  output logic                          busy,
  output logic                          done,
  output logic                          fault_exc,
  output logic [$clog2(NREG+1)-1:0]     xfer_count,
  output logic [AW-1:0]                 sp_adjust,
  output logic [$clog2(NREG)-1:0]       rf_raddr,
  input  logic [DW-1:0]                 rf_rdata,
  output logic                          rf_we,
  output logic [$clog2(NREG)-1:0]       rf_waddr,
  output logic [DW-1:0]                 rf_wdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [DW-1:0]                 mem_wdata,
  input  logic [DW-1:0]                 mem_rdata
);
  localparam int IW    = $clog2(NREG);
  localparam int CW    = $clog2(NREG + 1);
  localparam int NCH   = NREG / CHUNK;
  localparam int SW    = $clog2(NCH);
  localparam int BYTES = DW / 8;
  localparam int PW    = $clog2(PRECHK + 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_XFER, S_FIN} state_t;

  state_t          state;
  logic [NREG-1:0] win, eff, rem;
  logic [AW-1:0]   addr;
  logic            is_load;
  logic [PW-1:0]   chk_cnt;
  logic [CW-1:0]   count_q, pop_in;
  logic            exc_q;
  logic [IW-1:0]   idx;
  logic            last;

  for (genvar c = 0; c < NCH; c++) begin : g_win
    assign win[c*CHUNK +: CHUNK] = (!chunk_en || chunk_sel == SW'(c)) ? {CHUNK{1'b1}} : {CHUNK{1'b0}};
  end

  assign eff = live_mask & used_mask & win;

  always_comb begin
    pop_in = '0;
    for (int i = 0; i < NREG; i++) pop_in = pop_in + CW'(eff[i]);
  end

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (rem[i]) idx = IW'(i);
  end

  assign last = (rem & (rem - NREG'(1))) == '0;

  assign busy       = (state == S_CHECK) || (state == S_XFER);
  assign done       = (state == S_FIN);
  assign fault_exc  = exc_q;
  assign xfer_count = count_q;
  assign sp_adjust  = AW'(count_q) << $clog2(BYTES);
  assign mem_req    = (state == S_XFER);
  assign mem_we     = mem_req && !is_load;
  assign mem_addr   = addr;
  assign mem_wdata  = rf_rdata;
  assign rf_raddr   = idx;
  assign rf_we      = (state == S_XFER) && is_load;
  assign rf_waddr   = idx;
  assign rf_wdata   = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rem     <= '0;
      addr    <= '0;
      is_load <= 1'b0;
      chk_cnt <= '0;
      count_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          count_q <= pop_in;
          exc_q   <= 1'b0;
          rem     <= eff;
          addr    <= base_addr;
          is_load <= dir_load;
          chk_cnt <= '0;
          state   <= (eff == '0) ? S_FIN : S_CHECK;
        end
        S_CHECK: begin
          if (xlat_fault) begin
            exc_q <= 1'b1;
            rem   <= '0;
            state <= S_FIN;
          end else if (chk_cnt == PW'(PRECHK - 1)) begin
            state <= S_XFER;
          end else begin
            chk_cnt <= chk_cnt + PW'(1);
          end
        end
        S_XFER: begin
          rem[idx] <= 1'b0;
          addr     <= addr + AW'(BYTES);
          if (last) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + AW'(BYTES));

  // R2
  idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> rf_raddr > $past(rf_raddr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_exc |-> !mem_req && !rf_we);

  // R7
  precheck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mem_req && !rf_we);
endmodule

// File: tb/regmask_xfer_tb.sv
module regmask_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir_load = 1'b0, chunk_en = 1'b0, xlat_fault = 1'b0;
  logic [1:0]  chunk_sel = '0;
  logic [63:0] live_mask = '0, used_mask = '0;
  logic [31:0] base_addr = '0;
  logic        busy, done, fault_exc, rf_we, mem_req, mem_we;
  logic [6:0]  xfer_count;
  logic [31:0] sp_adjust, mem_addr;
  logic [5:0]  rf_raddr, rf_waddr;
  logic [63:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;

  logic [63:0] rf  [64];
  logic [63:0] mem [128];
  int traffic = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  regmask_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_load(dir_load),
    .chunk_en(chunk_en), .chunk_sel(chunk_sel), .live_mask(live_mask),
    .used_mask(used_mask), .base_addr(base_addr), .xlat_fault(xlat_fault),
    .busy(busy), .done(done), .fault_exc(fault_exc), .xfer_count(xfer_count),
    .sp_adjust(sp_adjust), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:3]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_we) mem[mem_addr[9:3]] <= mem_wdata;
    if (mem_req || rf_we) traffic <= traffic + 1;
  end

  function automatic logic [63:0] rfpat(int i);
    return {32'hC0DE_0000, 24'h0, 8'(i)};
  endfunction
  function automatic logic [63:0] mempat(int j);
    return {32'h5EED_0000, 24'h0, 8'(j)};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) rf[i] = rfpat(i);
    for (int j = 0; j < 128; j++) mem[j] = mempat(j);
  endtask

  task automatic launch(output int cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  localparam int NV = 6;
  localparam logic [63:0] V_LIVE [NV] = '{64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_FFFF_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_USED [NV] = '{64'h00FF_00FF_0F0F_F00F, 64'h00FF_00FF_0F0F_F00F,
    64'h8000_0000_0000_0001, 64'h0000_1234_0000_0000, 64'h0000_FFFF_0000_0000, 64'hF000_0000_0000_0000};
  localparam logic      V_CEN  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0] V_CSEL [NV] = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd3};
  localparam logic      V_LOAD [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] V_BASE [NV] = '{32'h100, 32'h180, 32'h040, 32'h200, 32'h100, 32'h300};

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, pop, bad, k, t0;
    logic [63:0] win, eff;
    fill();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy/done/exc/req/we", {59'd0, busy, done, fault_exc, mem_req, rf_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      fill();
      live_mask = V_LIVE[v]; used_mask = V_USED[v]; chunk_en = V_CEN[v];
      chunk_sel = V_CSEL[v]; dir_load = V_LOAD[v]; base_addr = V_BASE[v];
      win = V_CEN[v] ? (64'hFFFF << (16 * V_CSEL[v])) : '1;
      eff = V_LIVE[v] & V_USED[v] & win;
      pop = $countones(eff);
      t0 = traffic;
      launch(cyc);
      // R7 R9 R5 timing
      chk(pop == 0 ? "R5" : "R9", "cycles to done", 64'(cyc), pop == 0 ? 64'd1 : 64'(3 + pop + 1));
      // R6 count and stack adjust
      chk("R6", "xfer_count", 64'(xfer_count), 64'(pop));
      chk("R6", "sp_adjust", 64'(sp_adjust), 64'(pop * 8));
      chk(pop == 0 ? "R5" : "R7", "traffic cycles", 64'(traffic - t0), 64'(pop));
      bad = 0; k = 0;
      for (int i = 0; i < 64; i++) begin
        if (eff[i]) begin
          if (V_LOAD[v]) begin if (rf[i] !== mempat(V_BASE[v] / 8 + k)) bad++; end
          else if (mem[V_BASE[v] / 8 + k] !== rfpat(i)) bad++;
          k++;
        end else if (rf[i] !== rfpat(i)) bad++;
      end
      for (int j = 0; j < 128; j++)
        if (V_LOAD[v] || j < V_BASE[v] / 8 || j >= V_BASE[v] / 8 + pop)
          if (mem[j] !== mempat(j)) bad++;
      // R1 R2 R3 R4 data placement
      chk(V_LOAD[v] ? "R3" : (V_CEN[v] ? "R4" : "R2"), "misplaced words", 64'(bad), 64'd0);
      chk("R1", "fault_exc clear", 64'(fault_exc), 64'd0);
    end

    // R8 fault during pre-check
    fill();
    live_mask = '1; used_mask = 64'h0000_0000_00FF_00FF; chunk_en = 1'b0; dir_load = 1'b0;
    base_addr = 32'h80;
    t0 = traffic;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin start = 1'b0; xlat_fault = 1'b1; end
    cyc = 1;
    @(negedge clk); cyc++; xlat_fault = 1'b0;
    chk("R8", "done after fault", 64'(done), 64'd1);
    chk("R8", "fault_exc", 64'(fault_exc), 64'd1);
    @(negedge clk);
    chk("R8", "fault_exc held", 64'(fault_exc), 64'd1);
    chk("R9", "done single pulse", 64'(done), 64'd0);
    bad = 0;
    for (int j = 0; j < 128; j++) if (mem[j] !== mempat(j)) bad++;
    chk("R8", "memory untouched", 64'(bad), 64'd0);
    chk("R8", "traffic", 64'(traffic - t0), 64'd0);

    // R8 restore after fault: fault_exc clears on next start
    used_mask = 64'h1;
    launch(cyc);
    chk("R8", "fault_exc cleared", 64'(fault_exc), 64'd0);
    chk("R2", "single word", mem[32'h80 / 8], rfpat(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule